// File: doc/BRIEF.md
# Per-Thread Instruction Translation Buffer with Shared-Page Matching

This block is a small, fully associative translation buffer for the instruction side of one hardware thread in a multithreaded core. Every thread gets its own copy. It turns a virtual page number into a physical page number. Each slot stores a valid flag, a shared-page flag, a process tag, the virtual page and the physical page. The operating system marks pages that hold shared library code as shared. A shared slot matches a lookup whatever process tag the lookup carries, so a library translation loaded by one process serves every other process that runs on the thread.

A lookup is presented for one cycle. Its result (hit, physical page and shared flag) is registered and appears one cycle later. The instruction cache keeps the shared flag in its refilled line. On a miss the block raises a walk request and holds it until a fill for the same virtual page arrives. It then retries the lookup internally and reports the hit. Fills go to slots in round-robin order. An invalidate strobe removes every private slot owned by one process and keeps shared slots.

Top module: `itlb_thread`

## Requirements
- R1: After reset `rsp_valid` and `walk_req` are 0, the buffer holds no valid slot (the first lookup misses), and the replacement pointer starts at slot 0.
- R2: A lookup hits a private slot only if the slot is valid, its virtual page equals `lk_vpn` and its process tag equals `lk_pid`. The result (`rsp_valid`=1, `rsp_hit`=1, `rsp_ppn`) appears in the cycle after the request.
- R3: A valid slot with the shared flag set hits on an equal virtual page for any `lk_pid`. `rsp_shared` gives the shared flag of the slot that hit (1 shared, 0 private).
- R4: On a miss `rsp_valid`=1 and `rsp_hit`=0, and in that same cycle `walk_req` rises with `walk_vpn`/`walk_pid` equal to the request. It stays high with a stable `walk_vpn` until a fill whose `fill_vpn` equals `walk_vpn`.
- R5: After a matching fill is taken at a clock edge, `walk_req` is 0 in the next cycle. One cycle after that, the retried lookup reports `rsp_hit`=1 with the filled page and shared flag.
- R6: While `walk_req` is high, lookups on `lk_valid` are ignored: no response follows them and `walk_vpn` does not change.
- R7: A fill whose page differs from the pending walk is still installed, but `walk_req` stays high.
- R8: Fills write slots 0, 1, …, 15 in turn and then wrap, so the 17th fill after reset overwrites the translation installed by the 1st fill.
- R9: A cycle with `inv_valid`=1 clears every private slot whose tag equals `inv_pid`. Shared slots and slots of other processes keep hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_pid | input | 4 | Lookup process tag |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page to install |
| fill_pid | input | 4 | Process tag to install |
| fill_ppn | input | 20 | Physical page to install |
| fill_shared | input | 1 | Shared-page flag to install |
| inv_valid | input | 1 | Invalidate strobe |
| inv_pid | input | 4 | Process whose private slots are cleared |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | 20 | Physical page of the hit |
| rsp_shared | output | 1 | Shared flag of the hit, for the cache line |
| walk_req | output | 1 | Page walk needed |
| walk_vpn | output | 20 | Page to walk |
| walk_pid | output | 4 | Process tag of the walk |

## Verification
A lookup driven before edge E has its result on `rsp_valid`/`rsp_hit`/`rsp_ppn`/`rsp_shared` and, on a miss, on `walk_req` after E. The bench drives on falling edges and reads the result at the very next falling edge. After a matching fill is taken at edge E, `walk_req` is read as low at the falling edge after E, and the retried hit is read one falling edge later. Ignored lookups and invalidations are checked by reading `rsp_valid` or a later lookup at the same fixed offsets.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int PID_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_RETRY = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/itlb_match.sv
module itlb_match
  import itlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic [ENTRIES-1:0]            slot_valid,
  input  logic [ENTRIES-1:0]            slot_shared,
  input  logic [ENTRIES-1:0][PID_W-1:0] slot_pid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] slot_vpn,
  input  logic [VPN_W-1:0]              q_vpn,
  input  logic [PID_W-1:0]              q_pid,
  output logic [ENTRIES-1:0]            hit_vec
);
  // one comparator per slot; the process tag is a don't-care on shared slots
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = slot_valid[g] && (slot_vpn[g] == q_vpn) &&
                        (slot_shared[g] || (slot_pid[g] == q_pid));
  end
endmodule

// File: rtl/itlb_pick.sv
module itlb_pick
  import itlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic [ENTRIES-1:0]            hit_vec,
  input  logic [ENTRIES-1:0][PPN_W-1:0] slot_ppn,
  input  logic [ENTRIES-1:0]            slot_shared,
  output logic                          any_hit,
  output logic [PPN_W-1:0]              sel_ppn,
  output logic                          sel_shared
);
  // lowest slot index wins when several slots match
  always_comb begin
    sel_ppn    = '0;
    sel_shared = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_ppn    = slot_ppn[i];
        sel_shared = slot_shared[i];
      end
    end
    any_hit = |hit_vec;
  end
endmodule

// File: rtl/itlb_ctrl.sv
module itlb_ctrl
  import itlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             any_hit,
  output logic             q_en,
  output logic [VPN_W-1:0] q_vpn,
  output logic [PID_W-1:0] q_pid,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  output logic [PID_W-1:0] walk_pid
);
  ctl_state_e       st_q, st_d;
  logic [VPN_W-1:0] pend_vpn_q;
  logic [PID_W-1:0] pend_pid_q;
  logic             pend_ld;

  always_comb begin
    st_d    = st_q;
    q_en    = 1'b0;
    q_vpn   = lk_vpn;
    q_pid   = lk_pid;
    pend_ld = 1'b0;
    case (st_q)
      ST_IDLE: begin
        q_en = lk_valid;
        if (lk_valid && !any_hit) begin
          st_d    = ST_WALK;
          pend_ld = 1'b1;
        end
      end
      ST_WALK: begin
        if (fill_valid && (fill_vpn == pend_vpn_q)) st_d = ST_RETRY;
      end
      ST_RETRY: begin
        q_en  = 1'b1;
        q_vpn = pend_vpn_q;
        q_pid = pend_pid_q;
        st_d  = any_hit ? ST_IDLE : ST_WALK;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (pend_ld) begin
      pend_vpn_q <= lk_vpn;
      pend_pid_q <= lk_pid;
    end
  end

  assign walk_req = (st_q == ST_WALK);
  assign walk_vpn = pend_vpn_q;
  assign walk_pid = pend_pid_q;
endmodule

// File: rtl/itlb_thread.sv
module itlb_thread
  import itlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_shared,
  input  logic             inv_valid,
  input  logic [PID_W-1:0] inv_pid,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             rsp_shared,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  output logic [PID_W-1:0] walk_pid
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0]            shared_q;
  logic [ENTRIES-1:0][PID_W-1:0] pid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [IDX_W-1:0]              rr_q, rr_d;

  logic             q_en;
  logic [VPN_W-1:0] q_vpn;
  logic [PID_W-1:0] q_pid;
  logic [ENTRIES-1:0] hit_vec;
  logic             any_hit;
  logic [PPN_W-1:0] sel_ppn;
  logic             sel_shared;

  logic             rsp_valid_q, rsp_hit_q, rsp_shared_q;
  logic [PPN_W-1:0] rsp_ppn_q;

  itlb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vpn    (lk_vpn),
    .lk_pid    (lk_pid),
    .fill_valid(fill_valid),
    .fill_vpn  (fill_vpn),
    .any_hit   (any_hit),
    .q_en      (q_en),
    .q_vpn     (q_vpn),
    .q_pid     (q_pid),
    .walk_req  (walk_req),
    .walk_vpn  (walk_vpn),
    .walk_pid  (walk_pid)
  );

  itlb_match #(.ENTRIES(ENTRIES)) u_match (
    .slot_valid (valid_q),
    .slot_shared(shared_q),
    .slot_pid   (pid_q),
    .slot_vpn   (vpn_q),
    .q_vpn      (q_vpn),
    .q_pid      (q_pid),
    .hit_vec    (hit_vec)
  );

  itlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .hit_vec    (hit_vec),
    .slot_ppn   (ppn_q),
    .slot_shared(shared_q),
    .any_hit    (any_hit),
    .sel_ppn    (sel_ppn),
    .sel_shared (sel_shared)
  );

  // next state of the slot array: invalidate first, the fill slot overrides
  always_comb begin
    valid_d = valid_q;
    rr_d    = rr_q;
    if (inv_valid) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!shared_q[i] && (pid_q[i] == inv_pid)) valid_d[i] = 1'b0;
      end
    end
    if (fill_valid) begin
      valid_d[rr_q] = 1'b1;
      rr_d          = (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q     <= '0;
      rr_q        <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      valid_q     <= valid_d;
      rr_q        <= rr_d;
      rsp_valid_q <= q_en;
      rsp_hit_q   <= q_en && any_hit;
    end
  end

  // payload registers: no reset, written under their own enables
  always_ff @(posedge clk) begin
    if (fill_valid) begin
      shared_q[rr_q] <= fill_shared;
      pid_q[rr_q]    <= fill_pid;
      vpn_q[rr_q]    <= fill_vpn;
      ppn_q[rr_q]    <= fill_ppn;
    end
    if (q_en) begin
      rsp_ppn_q    <= sel_ppn;
      rsp_shared_q <= sel_shared;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_hit    = rsp_hit_q;
  assign rsp_ppn    = rsp_ppn_q;
  assign rsp_shared = rsp_shared_q;
endmodule

// File: rtl/itlb_thread_chk.sv
module itlb_thread_chk
  import itlb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             fill_valid,
  input logic [VPN_W-1:0] fill_vpn,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             walk_req,
  input logic [VPN_W-1:0] walk_vpn
);
  AST_MISS_RAISES_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> walk_req); // R4

  AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !(fill_valid && fill_vpn == walk_vpn)) |=> (walk_req && $stable(walk_vpn))); // R7

  AST_WALK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && fill_valid && fill_vpn == walk_vpn) |=> !walk_req); // R5

  AST_RETRY_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && fill_valid && fill_vpn == walk_vpn) |=> ##1 rsp_valid); // R5

  AST_NO_RSP_DURING_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |=> !rsp_valid); // R6
endmodule

bind itlb_thread itlb_thread_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fill_valid(fill_valid),
  .fill_vpn  (fill_vpn),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .walk_req  (walk_req),
  .walk_vpn  (walk_vpn)
);

// File: tb/itlb_thread_bench.sv
`timescale 1ns/1ps
module itlb_thread_bench;
  import itlb_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             lk_valid, fill_valid, fill_shared, inv_valid;
  logic [VPN_W-1:0] lk_vpn, fill_vpn;
  logic [PID_W-1:0] lk_pid, fill_pid, inv_pid;
  logic [PPN_W-1:0] fill_ppn;
  logic             rsp_valid, rsp_hit, rsp_shared, walk_req;
  logic [PPN_W-1:0] rsp_ppn;
  logic [VPN_W-1:0] walk_vpn;
  logic [PID_W-1:0] walk_pid;

  int n_chk   = 0;
  int n_fail  = 0;
  int n_fills = 0;

  always #10 clk = ~clk;

  itlb_thread u_itlb_thread (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
    .fill_ppn(fill_ppn), .fill_shared(fill_shared),
    .inv_valid(inv_valid), .inv_pid(inv_pid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .rsp_shared(rsp_shared), .walk_req(walk_req),
    .walk_vpn(walk_vpn), .walk_pid(walk_pid)
  );

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic             hit;
    logic [PPN_W-1:0] ppn;
    logic             sh;
  } vec_t;

  // lookups applied after the setup fills; misses are resolved with ppn/sh
  localparam vec_t VEC [8] = '{
    '{20'h00100, 4'd1, 1'b1, 20'h00AAA, 1'b0},
    '{20'h00100, 4'd2, 1'b0, 20'h00DDD, 1'b0},
    '{20'h00200, 4'd5, 1'b1, 20'h00BBB, 1'b1},
    '{20'h00200, 4'd2, 1'b1, 20'h00BBB, 1'b1},
    '{20'h00300, 4'd3, 1'b1, 20'h00CCC, 1'b0},
    '{20'h00400, 4'd3, 1'b0, 20'h00EEE, 1'b1},
    '{20'h00400, 4'd9, 1'b1, 20'h00EEE, 1'b1},
    '{20'h00100, 4'd2, 1'b1, 20'h00DDD, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p);
    lk_valid = 1'b1; lk_vpn = v; lk_pid = p;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                      input logic [PPN_W-1:0] pp, input logic sh);
    fill_valid = 1'b1; fill_vpn = v; fill_pid = p; fill_ppn = pp; fill_shared = sh;
    @(negedge clk);
    fill_valid = 1'b0;
    n_fills++;
  endtask

  task automatic expect_hit(input string tag, input logic [PPN_W-1:0] pp, input logic sh);
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " rsp_hit"}, 32'(rsp_hit), 32'd1);
    chk({tag, " rsp_ppn"}, 32'(rsp_ppn), 32'(pp));
    chk({tag, " rsp_shared"}, 32'(rsp_shared), 32'(sh));
  endtask

  task automatic expect_miss(input string tag, input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p);
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " rsp_hit"}, 32'(rsp_hit), 32'd0);
    chk({tag, " walk_req"}, 32'(walk_req), 32'd1);
    chk({tag, " walk_vpn"}, 32'(walk_vpn), 32'(v));
    chk({tag, " walk_pid"}, 32'(walk_pid), 32'(p));
  endtask

  // matching fill, then walk drop and retried hit (R5)
  task automatic resolve(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                         input logic [PPN_W-1:0] pp, input logic sh);
    fill(v, p, pp, sh);
    chk("R5 walk_req drops", 32'(walk_req), 32'd0);
    @(negedge clk);
    expect_hit("R5 retry", pp, sh);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0;
    lk_vpn = '0; lk_pid = '0; fill_vpn = '0; fill_pid = '0; fill_ppn = '0;
    fill_shared = 1'b0; inv_pid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1 walk_req after reset", 32'(walk_req), 32'd0);

    lookup(20'h00100, 4'd1);
    expect_miss("R1 R4 empty buffer", 20'h00100, 4'd1);

    lookup(20'h00777, 4'd1);
    chk("R6 ignored lookup rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R6 walk_vpn kept", 32'(walk_vpn), 32'h00100);

    fill(20'h00200, 4'd2, 20'h00BBB, 1'b1);
    chk("R7 walk_req held", 32'(walk_req), 32'd1);
    @(negedge clk);
    chk("R7 walk_req still held", 32'(walk_req), 32'd1);

    resolve(20'h00100, 4'd1, 20'h00AAA, 1'b0);
    fill(20'h00300, 4'd3, 20'h00CCC, 1'b0);

    // R2 R3 R4 R5 vector table
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      lookup(VEC[k].vpn, VEC[k].pid);
      if (VEC[k].hit) begin
        expect_hit(VEC[k].sh ? "R3 table" : "R2 table", VEC[k].ppn, VEC[k].sh);
      end else begin
        expect_miss("R4 table", VEC[k].vpn, VEC[k].pid);
        resolve(VEC[k].vpn, VEC[k].pid, VEC[k].ppn, VEC[k].sh);
      end
    end

    // R9 invalidate process 3
    @(negedge clk);
    inv_valid = 1'b1; inv_pid = 4'd3;
    @(negedge clk);
    inv_valid = 1'b0;
    lookup(20'h00400, 4'd3);
    expect_hit("R9 shared kept", 20'h00EEE, 1'b1);
    lookup(20'h00100, 4'd1);
    expect_hit("R9 other pid kept", 20'h00AAA, 1'b0);
    lookup(20'h00300, 4'd3);
    expect_miss("R9 private cleared", 20'h00300, 4'd3);
    resolve(20'h00300, 4'd3, 20'h00CCC, 1'b0);

    // R8 round robin: slot 0 holds the first fill (page 0x200, shared)
    while (n_fills < 16) fill(20'h00800 + VPN_W'(n_fills), 4'd1, PPN_W'(n_fills), 1'b0);
    lookup(20'h00200, 4'd7);
    expect_hit("R8 before wrap", 20'h00BBB, 1'b1);
    fill(20'h00900, 4'd1, 20'h00999, 1'b0);
    lookup(20'h00200, 4'd7);
    expect_miss("R8 evicted on wrap", 20'h00200, 4'd7);
    resolve(20'h00200, 4'd7, 20'h00BBB, 1'b1);
    lookup(20'h00900, 4'd1);
    expect_hit("R8 new slot", 20'h00999, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule